// File: doc/BRIEF.md
# Dual-Trigger Timestamp Counter with Partner Synchronisation

This block keeps a free-running timestamp that advances by one on every clock, and it takes snapshots of that timestamp when triggers arrive. Two independent capture channels exist. The local channel records the timestamp of this system's own trigger, and that value is used to pair coincident events. The cross channel records the timestamp of a trigger copy that comes from a partner system, so software can take the difference of the two and measure the time between the two systems' triggers.

Two counters running on one shared clock stay aligned only if they are cleared together. An external clear input forces the count to zero. When the block is the master, a run-start command clears its own count and, in the same cycle, raises a one-cycle clear pulse for the partner. The partner wires that pulse to its external clear input. Each capture channel is a small state machine with three states. `CAP_EMPTY` holds no unread value. `CAP_HELD` holds one unread value. `CAP_OVERRUN` holds a value that replaced an earlier one before software read it. The transitions are: EMPTY→HELD on a capture. HELD→OVERRUN on a capture without a read. HELD or OVERRUN→EMPTY on a read without a capture. HELD or OVERRUN→HELD on a capture and a read in the same cycle. The state stays put when neither happens.

Top module: `tsc_dual_stamp`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the count, both stamps, both valid flags, both overflow flags and the sync pulse are all zero.
- R2: When neither clear source is active, the count one cycle later equals the previous count plus one (modulo 2^TS_W).
- R3: When `ext_clr_i` is high at a clock edge, the count reads zero in the following cycle, whether or not the block is the master.
- R4: When `master_i` and `run_start_i` are both high at a clock edge, the count reads zero and `sync_clr_o` is high in the same following cycle. The pulse lasts one cycle for each cycle of command.
- R5: When `master_i` is low, `run_start_i` has no effect: `sync_clr_o` stays low and the count keeps incrementing.
- R6: A rising edge on `trig_local_i` stores the count that is visible in the cycle where the input is first high. From the next cycle on, `local_ts_o` shows that value and `local_valid_o` is high.
- R7: A rising edge on `trig_cross_i` stores the count into the cross register in the same way. It leaves the local register and its flags unchanged, and the local channel likewise leaves the cross channel unchanged.
- R8: A trigger held high for many cycles produces only one capture, so it sets no overflow by itself.
- R9: A capture while the channel already holds an unread value replaces the stamp with the newer count and raises the overflow flag. The overflow flag is never high without the valid flag.
- R10: A read strobe (`rd_local_i` / `rd_cross_i`) with no capture in that cycle clears valid and overflow in the next cycle. A read together with a capture leaves valid high, clears overflow, and keeps the new stamp.
- R11: A read strobe on an empty channel leaves the flags low and the stamp unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared timestamp clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | High when this block drives partner synchronisation |
| run_start_i | input | 1 | Run-start command, one cycle per request |
| ext_clr_i | input | 1 | External counter clear (from a partner's sync pulse) |
| trig_local_i | input | 1 | Local system trigger level |
| trig_cross_i | input | 1 | Partner system trigger copy, level |
| rd_local_i | input | 1 | Software read strobe for the local stamp |
| rd_cross_i | input | 1 | Software read strobe for the cross stamp |
| count_o | output | TS_W | Current timestamp |
| sync_clr_o | output | 1 | One-cycle clear pulse to the partner |
| local_ts_o | output | TS_W | Stamp of the latest local trigger |
| local_valid_o | output | 1 | Local stamp unread |
| local_ovf_o | output | 1 | Local stamp overwritten before read |
| cross_ts_o | output | TS_W | Stamp of the latest cross trigger |
| cross_valid_o | output | 1 | Cross stamp unread |
| cross_ovf_o | output | 1 | Cross stamp overwritten before read |

## Verification
The bound assertions check the cycle-level rules on every clock: the count step and both clear paths, that the sync pulse coincides with a zero count and occurs only under master command, that a trigger edge produces the expected stamp with valid set, that a read clears a channel, and that overflow implies valid. A per-cycle behavioural model in the bench covers what single properties cannot. This includes channel independence over long mixed sequences, a held trigger that never re-captures, the exact stamp left behind after overruns, the priority of a capture over a read in the same cycle, and a stamp taken in the same cycle as a clear, which keeps the count from before the clear.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int TS_W_DEF = 48;
    localparam int N_CHAN   = 2;
    localparam int CH_LOCAL = 0;
    localparam int CH_CROSS = 1;

    typedef enum logic [1:0] {
        CAP_EMPTY   = 2'd0,
        CAP_HELD    = 2'd1,
        CAP_OVERRUN = 2'd2
    } cap_state_e;

endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
    parameter int TS_W = 48
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic            master_i,
    input  logic            run_start_i,
    input  logic            ext_clr_i,
    output logic [TS_W-1:0] count_o,
    output logic            sync_clr_o
);

    logic            own_clr;
    logic [TS_W-1:0] count_q;
    logic            sync_q;

    assign own_clr = master_i & run_start_i;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            count_q <= '0;
            sync_q  <= 1'b0;
        end else begin
            sync_q <= own_clr;
            if (own_clr || ext_clr_i) begin
                count_q <= '0;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    assign count_o    = count_q;
    assign sync_clr_o = sync_q;

endmodule

// File: rtl/tsc_edge.sv
module tsc_edge (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic level_i,
    output logic rise_o
);

    logic prev_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_i;
        end
    end

    assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/tsc_capture.sv
module tsc_capture
    import tsc_pkg::*;
#(
    parameter int TS_W = 48
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic            cap_i,
    input  logic            rd_i,
    input  logic [TS_W-1:0] count_i,
    output logic [TS_W-1:0] ts_o,
    output logic            valid_o,
    output logic            ovf_o
);

    cap_state_e      state_q, state_d;
    logic [TS_W-1:0] ts_q;

    // State register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= CAP_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_EMPTY: begin
                if (cap_i) state_d = CAP_HELD;
            end
            CAP_HELD: begin
                if (cap_i && !rd_i)     state_d = CAP_OVERRUN;
                else if (!cap_i && rd_i) state_d = CAP_EMPTY;
            end
            CAP_OVERRUN: begin
                if (cap_i && rd_i)       state_d = CAP_HELD;
                else if (!cap_i && rd_i) state_d = CAP_EMPTY;
            end
            default: state_d = CAP_EMPTY;
        endcase
    end

    // Stamp storage
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            ts_q <= '0;
        end else if (cap_i) begin
            ts_q <= count_i;
        end
    end

    // Outputs
    always_comb begin
        ts_o    = ts_q;
        valid_o = 1'b0;
        ovf_o   = 1'b0;
        unique case (state_q)
            CAP_EMPTY:   ;
            CAP_HELD:    valid_o = 1'b1;
            CAP_OVERRUN: begin
                valid_o = 1'b1;
                ovf_o   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tsc_dual_stamp.sv
module tsc_dual_stamp
    import tsc_pkg::*;
#(
    parameter int TS_W = TS_W_DEF
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic            master_i,
    input  logic            run_start_i,
    input  logic            ext_clr_i,
    input  logic            trig_local_i,
    input  logic            trig_cross_i,
    input  logic            rd_local_i,
    input  logic            rd_cross_i,
    output logic [TS_W-1:0] count_o,
    output logic            sync_clr_o,
    output logic [TS_W-1:0] local_ts_o,
    output logic            local_valid_o,
    output logic            local_ovf_o,
    output logic [TS_W-1:0] cross_ts_o,
    output logic            cross_valid_o,
    output logic            cross_ovf_o
);

    logic [TS_W-1:0] count;
    logic [N_CHAN-1:0] trig_lvl, rd_stb, rise, valid, ovf;
    logic [TS_W-1:0] stamp [N_CHAN];

    assign trig_lvl[CH_LOCAL] = trig_local_i;
    assign trig_lvl[CH_CROSS] = trig_cross_i;
    assign rd_stb[CH_LOCAL]   = rd_local_i;
    assign rd_stb[CH_CROSS]   = rd_cross_i;

    tsc_counter #(.TS_W(TS_W)) u_cnt (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .master_i    (master_i),
        .run_start_i (run_start_i),
        .ext_clr_i   (ext_clr_i),
        .count_o     (count),
        .sync_clr_o  (sync_clr_o)
    );

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        tsc_edge u_edge (
            .clk_i   (clk_i),
            .rst_n_i (rst_n_i),
            .level_i (trig_lvl[c]),
            .rise_o  (rise[c])
        );

        tsc_capture #(.TS_W(TS_W)) u_cap (
            .clk_i   (clk_i),
            .rst_n_i (rst_n_i),
            .cap_i   (rise[c]),
            .rd_i    (rd_stb[c]),
            .count_i (count),
            .ts_o    (stamp[c]),
            .valid_o (valid[c]),
            .ovf_o   (ovf[c])
        );
    end

    assign count_o       = count;
    assign local_ts_o    = stamp[CH_LOCAL];
    assign local_valid_o = valid[CH_LOCAL];
    assign local_ovf_o   = ovf[CH_LOCAL];
    assign cross_ts_o    = stamp[CH_CROSS];
    assign cross_valid_o = valid[CH_CROSS];
    assign cross_ovf_o   = ovf[CH_CROSS];

endmodule

// File: rtl/tsc_dual_stamp_chk.sv
module tsc_dual_stamp_chk #(
    parameter int TS_W = 48
) (
    input logic            clk_i,
    input logic            rst_n_i,
    input logic            master_i,
    input logic            run_start_i,
    input logic            ext_clr_i,
    input logic            trig_local_i,
    input logic            trig_cross_i,
    input logic            rd_local_i,
    input logic            rd_cross_i,
    input logic [TS_W-1:0] count_o,
    input logic            sync_clr_o,
    input logic [TS_W-1:0] local_ts_o,
    input logic            local_valid_o,
    input logic            local_ovf_o,
    input logic [TS_W-1:0] cross_ts_o,
    input logic            cross_valid_o,
    input logic            cross_ovf_o
);

    p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!ext_clr_i && !(master_i && run_start_i)) |=> count_o == $past(count_o) + 1'b1);

    p_ext_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ext_clr_i |=> count_o == '0);

    p_sync_with_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (master_i && run_start_i) |=> (sync_clr_o && count_o == '0));

    p_sync_needs_master_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        sync_clr_o |-> $past(master_i && run_start_i));

    p_local_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (trig_local_i && !$past(trig_local_i)) |=> (local_valid_o && local_ts_o == $past(count_o)));

    p_cross_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (trig_cross_i && !$past(trig_cross_i)) |=> (cross_valid_o && cross_ts_o == $past(count_o)));

    p_local_ovf_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        local_ovf_o |-> local_valid_o);

    p_cross_ovf_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cross_ovf_o |-> cross_valid_o);

    p_local_read_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rd_local_i && !trig_local_i) |=> (!local_valid_o && !local_ovf_o));

    p_cross_read_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rd_cross_i && !trig_cross_i) |=> (!cross_valid_o && !cross_ovf_o));

endmodule

bind tsc_dual_stamp tsc_dual_stamp_chk #(.TS_W(TS_W)) u_chk (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n_i),
    .master_i      (master_i),
    .run_start_i   (run_start_i),
    .ext_clr_i     (ext_clr_i),
    .trig_local_i  (trig_local_i),
    .trig_cross_i  (trig_cross_i),
    .rd_local_i    (rd_local_i),
    .rd_cross_i    (rd_cross_i),
    .count_o       (count_o),
    .sync_clr_o    (sync_clr_o),
    .local_ts_o    (local_ts_o),
    .local_valid_o (local_valid_o),
    .local_ovf_o   (local_ovf_o),
    .cross_ts_o    (cross_ts_o),
    .cross_valid_o (cross_valid_o),
    .cross_ovf_o   (cross_ovf_o)
);

// File: tb/tsc_dual_stamp_tb_top.sv
`timescale 1ns/1ps
module tsc_dual_stamp_tb_top;

    localparam int TS_W = 48;
    localparam longint MASK = (64'd1 << TS_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master = 1'b0, run_start = 1'b0, ext_clr = 1'b0;
    logic trig_l = 1'b0, trig_c = 1'b0, rd_l = 1'b0, rd_c = 1'b0;

    logic [TS_W-1:0] count, ts_l, ts_c;
    logic sync, val_l, ovf_l, val_c, ovf_c;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tsc_dual_stamp #(.TS_W(TS_W)) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .master_i(master), .run_start_i(run_start),
        .ext_clr_i(ext_clr), .trig_local_i(trig_l), .trig_cross_i(trig_c),
        .rd_local_i(rd_l), .rd_cross_i(rd_c), .count_o(count), .sync_clr_o(sync),
        .local_ts_o(ts_l), .local_valid_o(val_l), .local_ovf_o(ovf_l),
        .cross_ts_o(ts_c), .cross_valid_o(val_c), .cross_ovf_o(ovf_c)
    );

    // Behavioural reference model
    longint m_count;
    bit     m_sync;
    longint m_ts [2];
    bit     m_val [2];
    bit     m_ovf [2];
    bit     m_prev [2];

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_count = 0;
        m_sync  = 0;
        for (int c = 0; c < 2; c++) begin
            m_ts[c] = 0; m_val[c] = 0; m_ovf[c] = 0; m_prev[c] = 0;
        end
    endtask

    task automatic model_step();
        bit lvl [2];
        bit rd [2];
        lvl[0] = trig_l; lvl[1] = trig_c;
        rd[0]  = rd_l;   rd[1]  = rd_c;
        for (int c = 0; c < 2; c++) begin
            bit rise;
            rise = lvl[c] && !m_prev[c];
            m_prev[c] = lvl[c];
            if (rise) begin
                m_ts[c] = m_count;
                if (m_val[c] && !rd[c]) m_ovf[c] = 1;
                else m_ovf[c] = 0;
                m_val[c] = 1;
            end else if (rd[c]) begin
                m_val[c] = 0;
                m_ovf[c] = 0;
            end
        end
        m_sync = master && run_start;
        if (ext_clr || (master && run_start)) m_count = 0;
        else m_count = (m_count + 1) & MASK;
    endtask

    task automatic compare_all();
        chk("R2", "count", longint'(count), m_count);
        chk("R4", "sync", longint'(sync), longint'(m_sync));
        chk("R6", "local_ts", longint'(ts_l), m_ts[0]);
        chk("R6", "local_valid", longint'(val_l), longint'(m_val[0]));
        chk("R9", "local_ovf", longint'(ovf_l), longint'(m_ovf[0]));
        chk("R7", "cross_ts", longint'(ts_c), m_ts[1]);
        chk("R7", "cross_valid", longint'(val_c), longint'(m_val[1]));
        chk("R9", "cross_ovf", longint'(ovf_c), longint'(m_ovf[1]));
    endtask

    // One clock: model follows the edge, compare at the falling edge
    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic clear_strobes();
        run_start = 0; ext_clr = 0; rd_l = 0; rd_c = 0;
    endtask

    initial begin
        longint snap;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1", "count in reset", longint'(count), 0);
        chk("R1", "sync in reset", longint'(sync), 0);
        chk("R1", "flags in reset", longint'({val_l, ovf_l, val_c, ovf_c}), 0);
        rst_n = 1;
        cyc(1);
        // R1: first cycle after reset
        chk("R1", "stamps after reset", longint'(ts_l | ts_c), 0);

        // R2: free running
        cyc(6);
        chk("R2", "count after 7 cycles", longint'(count), 7);

        // R6: single local pulse
        trig_l = 1; snap = longint'(count);
        cyc(1); trig_l = 0;
        chk("R6", "local stamp", longint'(ts_l), snap);
        chk("R6", "local valid", longint'(val_l), 1);
        cyc(2);

        // R10: read clears
        rd_l = 1; cyc(1); clear_strobes();
        chk("R10", "valid after read", longint'(val_l), 0);

        // R11: read on empty channel
        snap = longint'(ts_l);
        rd_l = 1; cyc(1); clear_strobes();
        chk("R11", "stamp after empty read", longint'(ts_l), snap);
        chk("R11", "flags after empty read", longint'({val_l, ovf_l}), 0);

        // R8: held trigger captures once
        trig_l = 1; snap = longint'(count);
        cyc(6);
        chk("R8", "no overflow on held level", longint'(ovf_l), 0);
        chk("R8", "stamp from first cycle", longint'(ts_l), snap);
        trig_l = 0; cyc(1);

        // R9: second edge before read
        trig_l = 1; snap = longint'(count); cyc(1); trig_l = 0; cyc(1);
        chk("R9", "overflow raised", longint'(ovf_l), 1);
        chk("R9", "newest stamp kept", longint'(ts_l), snap);

        // R10: read with capture in the same cycle
        trig_l = 1; rd_l = 1; snap = longint'(count); cyc(1); clear_strobes(); trig_l = 0;
        chk("R10", "valid kept on read+capture", longint'(val_l), 1);
        chk("R10", "overflow cleared on read+capture", longint'(ovf_l), 0);
        chk("R10", "new stamp on read+capture", longint'(ts_l), snap);

        // R7: cross channel independent
        snap = longint'(ts_l);
        trig_c = 1; cyc(1); trig_c = 0; cyc(1);
        chk("R7", "cross valid", longint'(val_c), 1);
        chk("R7", "local untouched", longint'(ts_l), snap);
        rd_c = 1; cyc(1); clear_strobes();
        chk("R7", "local valid untouched by cross read", longint'(val_l), 1);

        // R3: external clear
        cyc(5);
        ext_clr = 1; cyc(1); clear_strobes();
        chk("R3", "count after external clear", longint'(count), 0);

        // R5: run start ignored when not master
        cyc(4);
        snap = longint'(count);
        run_start = 1; cyc(1); clear_strobes();
        chk("R5", "no sync pulse", longint'(sync), 0);
        chk("R5", "count kept running", longint'(count), snap + 1);

        // R4: master run start, with triggers in the same cycle
        master = 1; cyc(3);
        rd_l = 1; cyc(1); clear_strobes();
        snap = longint'(count);
        run_start = 1; trig_l = 1; trig_c = 1;
        cyc(1); clear_strobes(); trig_l = 0; trig_c = 0;
        chk("R4", "sync pulse", longint'(sync), 1);
        chk("R4", "count zero with pulse", longint'(count), 0);
        chk("R6", "stamp holds pre-clear count", longint'(ts_l), snap);
        cyc(1);
        chk("R4", "pulse one cycle", longint'(sync), 0);

        // Mixed traffic against the model
        for (int i = 0; i < 2000; i++) begin
            master    = ($urandom % 4) != 0;
            run_start = ($urandom % 40) == 0;
            ext_clr   = ($urandom % 50) == 0;
            trig_l    = ($urandom % 3) == 0;
            trig_c    = ($urandom % 4) == 0;
            rd_l      = ($urandom % 5) == 0;
            rd_c      = ($urandom % 6) == 0;
            cyc(1);
        end
        clear_strobes(); trig_l = 0; trig_c = 0;
        cyc(2);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule